// File: doc/BRIEF.md
# SDRAM Write Burst Sequencer

This block is the device-side write path of a four-bank synchronous DRAM with a 32-bit data bus. It watches the command pins and recognises WRITE commands. On each WRITE it takes the bank, the starting column and the auto-precharge choice. It then produces one array write per clock for the length of the burst. Each write carries a column address, a bank, the data word and a strobe, and goes to the internal storage array.

There is no prefetch. The word presented with the WRITE is the first beat, and each following clock supplies the next beat. Burst length and ordering come from static configuration inputs. A fixed burst of 1, 2, 4 or 8 ends by itself. A full-page burst steps through the columns forever, wrapping past the last column, until another WRITE replaces it. A WRITE may arrive on any clock and cuts off the burst in flight at once. When a burst that asked for auto precharge runs to its end, the block raises a one-cycle precharge request for that bank.

Top module: `sdram_wr_burst_seq`

## Requirements
- R1: A WRITE is decoded when cke=1, cs_n=0, ras_n=1, cas_n=0 and we_n=0 at a rising edge. That edge captures dq_in as the first beat, and arr_we, arr_col, arr_bank and arr_data show that beat in the following cycle.
- R2: After the first beat, the burst produces one beat per clock with no gap, and arr_bank stays at the commanded bank.
- R3: Once a fixed-length burst has delivered its last beat and no new WRITE has arrived, arr_we stays low and dq_in is ignored.
- R4: With cfg_bl=3'b111 (full page), the column rises by one per beat modulo 256, passes from 255 to 0, and runs until a new WRITE arrives.
- R5: A WRITE during a burst ends that burst at once. The beat captured on the same edge belongs to the new command and is written at the new bank and column.
- R6: The starting column is addr[7:0] and the bank is ba[1:0]. addr[9:8] has no effect on a WRITE.
- R7: When addr[10]=1 with the WRITE, pre_req is high for exactly the cycle that carries the last beat, and it refers to the bank on arr_bank. When addr[10]=0, pre_req stays low.
- R8: An auto-precharge burst cut off by a new WRITE never raises pre_req.
- R9: cfg_bl selects a fixed length as 0→1, 1→2, 2→4, 3→8. Codes 4 to 6 act as length 1. In sequential order (cfg_interleave=0), the column of beat i is (start & ~(L-1)) | ((start+i) mod L), so it wraps inside the aligned block.
- R10: With cfg_interleave=1 and a fixed length, the column of beat i is start XOR i. A full-page burst ignores cfg_interleave.
- R11: When the pins do not form a WRITE, the burst in progress is unaffected. This includes cs_n=1, cke=0 and other pin codes.
- R12: While reset is asserted, and in the cycles it takes to release it, arr_we and pre_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released through a two-stage synchroniser |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Address pins: [7:0] column, [10] auto precharge |
| ba | input | 2 | Bank select |
| dq_in | input | 32 | Write data bus |
| cfg_bl | input | 3 | Burst length code |
| cfg_interleave | input | 1 | 1 = interleaved order, 0 = sequential order |
| arr_we | output | 1 | Array write strobe |
| arr_bank | output | 2 | Bank of the current array write |
| arr_col | output | 8 | Column of the current array write |
| arr_data | output | 32 | Data of the current array write |
| pre_req | output | 1 | Precharge request for arr_bank, one cycle |

## Verification
Every array write, together with any precharge request, appears exactly one cycle after the rising edge that captured its data word. The bench drives the pins after a falling edge. At that moment it updates a queue of expected beats: a WRITE clears the queue and loads the new burst. The bench then pops the beat due at the coming rising edge and compares it at the next falling edge, so each comparison falls in the cycle where the registered outputs hold that beat. Truncation shows up as queued beats that are discarded, and a missing or extra pre_req shows up against the flag stored with each queued beat.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

  typedef enum logic [2:0] {
    BL_ONE  = 3'd0,
    BL_TWO  = 3'd1,
    BL_FOUR = 3'd2,
    BL_EIGHT= 3'd3,
    BL_PAGE = 3'd7
  } bl_code_e;

  // Block mask (length-1) for fixed lengths; reserved codes act as length 1.
  function automatic logic [3:0] bl_mask(input logic [2:0] code);
    case (code)
      BL_TWO:   bl_mask = 4'd1;
      BL_FOUR:  bl_mask = 4'd3;
      BL_EIGHT: bl_mask = 4'd7;
      default:  bl_mask = 4'd0;
    endcase
  endfunction

  function automatic logic bl_is_page(input logic [2:0] code);
    bl_is_page = (code == BL_PAGE);
  endfunction

endpackage

// File: rtl/sdram_wr_rst_sync.sv
module sdram_wr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sh_q[STAGES-1];
endmodule

// File: rtl/sdram_wr_cmd_dec.sv
module sdram_wr_cmd_dec (
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic wr_cmd
);
  always_comb begin
    wr_cmd = cke && !cs_n && ras_n && !cas_n && !we_n;
  end
endmodule

// File: rtl/sdram_wr_col_gen.sv
module sdram_wr_col_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             page,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;

  always_comb begin
    sum = start + idx;
    if (page)     col = sum;
    else if (ilv) col = start ^ (idx & mask);
    else          col = (start & ~mask) | (sum & mask);
  end
endmodule

// File: rtl/sdram_wr_burst_seq.sv
module sdram_wr_burst_seq
  import sdram_wr_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int DATA_W = 32,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [AP_BIT:0]   addr,
  input  logic [BANK_W-1:0] ba,
  input  logic [DATA_W-1:0] dq_in,
  input  logic [2:0]        cfg_bl,
  input  logic              cfg_interleave,
  output logic              arr_we,
  output logic [BANK_W-1:0] arr_bank,
  output logic [COL_W-1:0]  arr_col,
  output logic [DATA_W-1:0] arr_data,
  output logic              pre_req
);
  localparam int RS_STAGES = 2;

  logic rst_q_n;
  logic wr_cmd;

  // burst state
  logic              busy_q, busy_d;
  logic [COL_W-1:0]  cnt_q, cnt_d;
  logic [COL_W-1:0]  start_q, start_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              ap_q, ap_d;
  logic [COL_W-1:0]  mask_q, mask_d;
  logic              page_q, page_d;
  logic              ilv_q, ilv_d;
  logic              st_en;

  // output next values
  logic              we_d, pre_d;
  logic [BANK_W-1:0] obank_d;
  logic [COL_W-1:0]  ocol_d;
  logic [COL_W-1:0]  gen_col;
  logic              last_beat;

  logic unused_addr_bits;
  assign unused_addr_bits = ^addr[AP_BIT-1:COL_W];

  sdram_wr_rst_sync #(.STAGES(RS_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  sdram_wr_cmd_dec u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .wr_cmd(wr_cmd)
  );

  sdram_wr_col_gen #(.COL_W(COL_W)) u_col (
    .start(start_q), .idx(cnt_q), .mask(mask_q), .page(page_q),
    .ilv(ilv_q), .col(gen_col)
  );

  // next-state
  always_comb begin
    busy_d    = busy_q;
    cnt_d     = cnt_q;
    start_d   = start_q;
    bank_d    = bank_q;
    ap_d      = ap_q;
    mask_d    = mask_q;
    page_d    = page_q;
    ilv_d     = ilv_q;
    st_en     = 1'b0;
    we_d      = 1'b0;
    pre_d     = 1'b0;
    obank_d   = bank_q;
    ocol_d    = gen_col;
    last_beat = 1'b0;
    if (wr_cmd) begin
      st_en     = 1'b1;
      start_d   = addr[COL_W-1:0];
      bank_d    = ba;
      ap_d      = addr[AP_BIT];
      mask_d    = COL_W'(bl_mask(cfg_bl));
      page_d    = bl_is_page(cfg_bl);
      ilv_d     = cfg_interleave;
      last_beat = !bl_is_page(cfg_bl) && (bl_mask(cfg_bl) == 4'd0);
      busy_d    = !last_beat;
      cnt_d     = COL_W'(1);
      we_d      = 1'b1;
      pre_d     = last_beat && addr[AP_BIT];
      obank_d   = ba;
      ocol_d    = addr[COL_W-1:0];
    end else if (busy_q) begin
      st_en     = 1'b1;
      last_beat = !page_q && (cnt_q == mask_q);
      busy_d    = !last_beat;
      cnt_d     = cnt_q + COL_W'(1);
      we_d      = 1'b1;
      pre_d     = last_beat && ap_q;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      busy_q  <= 1'b0;
      arr_we  <= 1'b0;
      pre_req <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      arr_we  <= we_d;
      pre_req <= pre_d;
    end
  end

  // datapath registers, enable only
  always_ff @(posedge clk) begin
    if (st_en) begin
      cnt_q    <= cnt_d;
      start_q  <= start_d;
      bank_q   <= bank_d;
      ap_q     <= ap_d;
      mask_q   <= mask_d;
      page_q   <= page_d;
      ilv_q    <= ilv_d;
      arr_bank <= obank_d;
      arr_col  <= ocol_d;
      arr_data <= dq_in;
    end
  end

  // ---------------- assertions ----------------
  p_first_beat_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_cmd |=> (arr_we && arr_col == $past(addr[COL_W-1:0]) &&
                arr_bank == $past(ba) && arr_data == $past(dq_in)));

  p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy_q && !wr_cmd) |=> (arr_we && arr_bank == $past(bank_q)));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy_q && !wr_cmd) |=> !arr_we);

  p_page_step_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy_q && page_q && !wr_cmd) |=> (arr_col == $past(arr_col) + COL_W'(1)));

  p_pre_with_beat_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    pre_req |-> arr_we);

  p_trunc_pre_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_cmd |=> (pre_req == $past(addr[AP_BIT] && (cfg_bl inside {3'd0, 3'd4, 3'd5, 3'd6}))));

endmodule

// File: tb/sdram_wr_burst_seq_bench.sv
module sdram_wr_burst_seq_bench;

  typedef struct {
    logic [1:0] bank;
    logic [7:0] col;
    logic       pre;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [10:0] addr;
  logic [1:0]  ba;
  logic [31:0] dq_in;
  logic [2:0]  cfg_bl;
  logic        cfg_interleave;
  logic        arr_we;
  logic [1:0]  arr_bank;
  logic [7:0]  arr_col;
  logic [31:0] arr_data;
  logic        pre_req;

  int checks = 0;
  int failures = 0;
  int cyc_no = 0;
  bit finished = 0;
  beat_t q[$];

  always #2 clk = ~clk;

  sdram_wr_burst_seq u_sdram_wr_burst_seq (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .dq_in(dq_in),
    .cfg_bl(cfg_bl), .cfg_interleave(cfg_interleave), .arr_we(arr_we),
    .arr_bank(arr_bank), .arr_col(arr_col), .arr_data(arr_data),
    .pre_req(pre_req)
  );

  task automatic load_burst(input logic [1:0] b, input int start, input bit ap);
    int len;
    q.delete();
    if (cfg_bl == 3'b111) begin
      for (int i = 0; i < 300; i++) q.push_back('{b, 8'((start + i) % 256), 1'b0});
    end else begin
      len = (cfg_bl == 3'd1) ? 2 : (cfg_bl == 3'd2) ? 4 : (cfg_bl == 3'd3) ? 8 : 1;
      for (int i = 0; i < len; i++) begin
        int c;
        if (cfg_interleave) c = start ^ i;
        else c = (start & ~(len - 1)) | ((start + i) % len);
        q.push_back('{b, 8'(c), (ap && i == len - 1)});
      end
    end
  endtask

  // one clock: pins applied now, result compared one cycle after the edge
  task automatic cyc(input logic k, input logic cs, input logic ras, input logic cas,
                     input logic we, input logic [10:0] a, input logic [1:0] b,
                     input string tag);
    bit    have;
    beat_t e;
    logic [31:0] d;
    d = 32'hA500_0000 + 32'(cyc_no);
    cke = k; cs_n = cs; ras_n = ras; cas_n = cas; we_n = we;
    addr = a; ba = b; dq_in = d;
    if (k && !cs && ras && !cas && !we) load_burst(b, int'(a[7:0]), a[10]);
    have = (q.size() > 0);
    if (have) e = q.pop_front();
    @(posedge clk);
    @(negedge clk);
    cyc_no++;
    checks++;
    if (arr_we !== have) begin
      failures++;
      $display("FAIL %s cycle %0d arr_we actual=%b expected=%b", tag, cyc_no, arr_we, have);
    end else if (have) begin
      checks++;
      if (arr_bank !== e.bank || arr_col !== e.col || arr_data !== d || pre_req !== e.pre) begin
        failures++;
        $display("FAIL %s cycle %0d bank/col/data/pre actual=%0d/%0d/%h/%b expected=%0d/%0d/%h/%b",
                 tag, cyc_no, arr_bank, arr_col, arr_data, pre_req, e.bank, e.col, d, e.pre);
      end
    end else begin
      checks++;
      if (pre_req !== 1'b0) begin
        failures++;
        $display("FAIL %s cycle %0d pre_req actual=%b expected=0", tag, cyc_no, pre_req);
      end
    end
  endtask

  task automatic wr(input int col, input logic [1:0] b, input bit ap, input logic [1:0] hi,
                    input string tag);
    cyc(1, 0, 1, 0, 0, {ap, hi, 8'(col)}, b, tag);
  endtask

  task automatic nop(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, 1, 1, 1, 11'h0, 2'd0, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
    addr = '0; ba = '0; dq_in = '0;
    cfg_bl = 3'd0; cfg_interleave = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (arr_we !== 1'b0 || pre_req !== 1'b0) begin
      failures++;
      $display("FAIL R12 reset we/pre actual=%b/%b expected=0/0", arr_we, pre_req);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (arr_we !== 1'b0 || pre_req !== 1'b0) begin
      failures++;
      $display("FAIL R12 release we/pre actual=%b/%b expected=0/0", arr_we, pre_req);
    end
    nop(2, "R12");

    // R1 R7: single beat with auto precharge, then without
    cfg_bl = 3'd0;
    wr(17, 2'd1, 1, 2'b00, "R1_R7");
    nop(2, "R3");
    wr(18, 2'd2, 0, 2'b00, "R7_noap");
    nop(1, "R3");
    // R9: reserved code 5 acts as length 1
    cfg_bl = 3'd5;
    wr(40, 2'd3, 1, 2'b00, "R9_reserved");
    nop(2, "R3");

    // R9 R2: length 4 sequential, start 6 -> 6,7,4,5
    cfg_bl = 3'd2;
    wr(6, 2'd2, 1, 2'b00, "R9_seq4");
    nop(5, "R2_R3");
    // R9: length 2 sequential, start 3 -> 3,2
    cfg_bl = 3'd1;
    wr(3, 2'd0, 0, 2'b00, "R9_seq2");
    nop(3, "R3");

    // R10: length 8 interleaved, start 5
    cfg_bl = 3'd3; cfg_interleave = 1'b1;
    wr(5, 2'd1, 1, 2'b00, "R10_ilv8");
    nop(9, "R10_R3");
    cfg_interleave = 1'b0;

    // R5: back-to-back length 2 writes to different banks every clock
    cfg_bl = 3'd1;
    wr(10, 2'd0, 1, 2'b00, "R5_b2b");
    wr(20, 2'd1, 1, 2'b00, "R5_b2b");
    wr(30, 2'd2, 0, 2'b00, "R5_b2b");
    wr(41, 2'd3, 1, 2'b00, "R5_b2b");
    nop(3, "R3");

    // R8: length 8 with auto precharge cut off after 3 beats
    cfg_bl = 3'd3;
    wr(8, 2'd2, 1, 2'b00, "R8_trunc");
    nop(2, "R8_trunc");
    wr(0, 2'd3, 0, 2'b00, "R8_R5");
    nop(9, "R8_R3");
    // cut off exactly at the would-be last beat
    cfg_bl = 3'd2;
    wr(12, 2'd1, 1, 2'b00, "R8_edge");
    nop(2, "R8_edge");
    wr(50, 2'd0, 0, 2'b00, "R8_edge");
    nop(5, "R3");

    // R6: addr[9:8] set, ignored
    cfg_bl = 3'd1;
    wr(9, 2'd3, 1, 2'b11, "R6_hibits");
    nop(3, "R6");

    // R11: non-WRITE codes during a burst
    cfg_bl = 3'd3;
    wr(16, 2'd0, 1, 2'b00, "R11");
    cyc(1, 1, 1, 0, 0, 11'h0AA, 2'd3, "R11_csn");
    cyc(0, 0, 1, 0, 0, 11'h0AA, 2'd3, "R11_cke");
    cyc(1, 0, 0, 1, 1, 11'h0AA, 2'd3, "R11_other");
    cyc(1, 0, 1, 0, 1, 11'h0AA, 2'd3, "R11_other");
    nop(5, "R11_R3");
    cyc(1, 1, 1, 0, 0, 11'h0AA, 2'd3, "R11_idle");

    // R4 R10: full page from 250 with interleave set, wraps past 255
    cfg_bl = 3'd7; cfg_interleave = 1'b1;
    wr(250, 2'd2, 1, 2'b00, "R4_page");
    nop(14, "R4_wrap");
    cfg_interleave = 1'b0;
    cfg_bl = 3'd0;
    wr(77, 2'd1, 0, 2'b00, "R4_R5_stop");
    nop(4, "R3");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule